// File: doc/BRIEF.md
# Received Frame Message Object Updater

This block applies a received CAN frame to the message object that acceptance filtering has already matched. It takes the object's index and its current contents, read from object storage, together with the received frame. It works out the new contents and hands them back to storage through one write strobe. Data frames and remote frames follow separate flag rules. On a data frame, overwriting data that has not yet been read raises a lost-data flag. On a remote frame, the object's direction, remote-enable and mask-enable bits choose one of three treatments.

A `start_i` pulse with `found_i` high hands over a match. The write then appears one cycle later, and `busy_o` is high for that one cycle. The CPU clears the new-data and lost-data flags through a separate port. Object storage applies those clears itself. The updater also folds any clear aimed at the object it is handling into its own result, so a flag it is setting in that cycle stays set.

Top module: `rx_obj_update`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy_o`, `wr_o` and every bit of `irq_o` are 0.
- R2: A `start_i` that arrives while `busy_o` is 0 is accepted. `busy_o` and the write strobe are then high in the following cycle only, with `wr_idx_o` equal to the accepted index. A `start_i` that arrives while `busy_o` is 1 is ignored.
- R3: An accepted start with `found_i` = 0 produces no write.
- R4: On a data frame (`remote_i` = 0) the written object carries the received identifier, IDE, RTR, DLC and data. In the written flags, TxRqst (bit 0) is 0 and NewDat (bit 1) is 1.
- R5: On a data frame, the written MsgLst (bit 2) is 1 if NewDat was already 1. Otherwise MsgLst keeps its previous value.
- R6: On a data frame with RxIE (bit 4) set, IntPnd (bit 3) is written as 1 and `irq_o` is one-hot at the object index during the write. With RxIE clear, IntPnd keeps its value and `irq_o` stays 0. `irq_o` is 0 for remote frames.
- R7: On a remote frame to an object with Dir (bit 7) and RmtEn (bit 5) both 1, the written object equals the stored one except that TxRqst is 1. This holds for either value of UMask (bit 6).
- R8: A remote frame is ignored, with no write, when Dir is 0, or when Dir is 1 and both RmtEn and UMask are 0.
- R9: On a remote frame with Dir = 1, RmtEn = 0 and UMask = 1, the write clears TxRqst, sets NewDat, stores the received identifier, IDE, RTR and DLC, and keeps the stored data bytes.
- R10: A CPU clear of NewDat or MsgLst aimed at the handled object counts in both the accept cycle and the write cycle. When the clear collides with a flag the handler sets, the set wins. A clear in the accept cycle counts as happening before the frame, so it also decides MsgLst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Acceptance result is valid this cycle |
| found_i | input | 1 | A matching object was found |
| idx_i | input | IDX_W | Index of the matched object |
| remote_i | input | 1 | Received frame is a remote frame |
| flags_i | input | 8 | Stored control flags of the matched object |
| id_i | input | ID_W | Stored identifier |
| ide_i | input | 1 | Stored extended-identifier bit |
| rtr_i | input | 1 | Stored remote bit |
| dlc_i | input | 4 | Stored data length code |
| data_i | input | 8*DATA_BYTES | Stored data bytes |
| rx_id_i | input | ID_W | Received identifier |
| rx_ide_i | input | 1 | Received extended-identifier bit |
| rx_rtr_i | input | 1 | Received remote bit |
| rx_dlc_i | input | 4 | Received data length code |
| rx_data_i | input | 8*DATA_BYTES | Received data bytes |
| clr_i | input | 1 | CPU flag-clear request |
| clr_idx_i | input | IDX_W | Object targeted by the clear |
| clr_newdat_i | input | 1 | Clear NewDat |
| clr_lost_i | input | 1 | Clear MsgLst |
| busy_o | output | 1 | An update is in flight |
| wr_o | output | 1 | Write strobe to object storage |
| wr_idx_o | output | IDX_W | Index being written |
| flags_o | output | 8 | Flags to write |
| id_o | output | ID_W | Identifier to write |
| ide_o | output | 1 | Extended-identifier bit to write |
| rtr_o | output | 1 | Remote bit to write |
| dlc_o | output | 4 | Data length code to write |
| data_o | output | 8*DATA_BYTES | Data bytes to write |
| irq_o | output | NUM_OBJ | Per-object interrupt-pending request |

## Verification
The assertions check the timing on every cycle: one busy cycle for each accepted start, the write strobe confined to that cycle, no write after a missed match or an ignored remote frame, and a one-hot interrupt vector. They also check the flag results that follow from the inputs of the accept cycle alone. These are NewDat and TxRqst after a data frame, TxRqst after each remote case, and the stored data bytes kept on remote frames. Only the bench's scenarios show the rest. That includes the exact identifier, DLC and data values written, the MsgLst and IntPnd outcomes, and how a CPU clear resolves when it collides in the accept cycle or in the write cycle.

// File: rtl/rx_obj_pkg.sv
package rx_obj_pkg;
    localparam int FLAG_W  = 8;
    localparam int F_TXRQ  = 0;
    localparam int F_NEWD  = 1;
    localparam int F_LOST  = 2;
    localparam int F_IPND  = 3;
    localparam int F_RXIE  = 4;
    localparam int F_RMTEN = 5;
    localparam int F_UMASK = 6;
    localparam int F_DIR   = 7;

    typedef enum logic [1:0] {
        UPD_NONE,
        UPD_DATA,
        UPD_RMT_TX,
        UPD_RMT_STORE
    } upd_kind_e;
endpackage

// File: rtl/rx_obj_rules.sv
module rx_obj_rules
    import rx_obj_pkg::*;
(
    input  logic              found_i,
    input  logic              remote_i,
    input  logic [FLAG_W-1:0] flags_i,
    output upd_kind_e         kind_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [FLAG_W-1:0] set_o
);
    logic [FLAG_W-1:0] base;

    always_comb begin
        kind_o = UPD_NONE;
        base   = flags_i;
        set_o  = '0;
        if (found_i) begin
            if (!remote_i) begin
                kind_o         = UPD_DATA;
                set_o[F_NEWD]  = 1'b1;
                set_o[F_LOST]  = flags_i[F_NEWD];
                set_o[F_IPND]  = flags_i[F_RXIE];
                base[F_TXRQ]   = 1'b0;
            end else if (flags_i[F_DIR] && flags_i[F_RMTEN]) begin
                kind_o         = UPD_RMT_TX;
                set_o[F_TXRQ]  = 1'b1;
            end else if (flags_i[F_DIR] && flags_i[F_UMASK]) begin
                kind_o         = UPD_RMT_STORE;
                set_o[F_NEWD]  = 1'b1;
                base[F_TXRQ]   = 1'b0;
            end
        end
        flags_o = base | set_o;
    end
endmodule

// File: rtl/rx_obj_clr_mask.sv
module rx_obj_clr_mask
    import rx_obj_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clr_i,
    input  logic [IDX_W-1:0]  clr_idx_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              clr_newdat_i,
    input  logic              clr_lost_i,
    output logic [FLAG_W-1:0] mask_o
);
    logic hit;

    always_comb begin
        hit            = clr_i && (clr_idx_i == idx_i);
        mask_o         = '0;
        mask_o[F_NEWD] = hit && clr_newdat_i;
        mask_o[F_LOST] = hit && clr_lost_i;
    end
endmodule

// File: rtl/rx_obj_onehot.sv
module rx_obj_onehot #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N-1:0]     vec_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign vec_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/rx_obj_update.sv
module rx_obj_update
    import rx_obj_pkg::*;
#(
    parameter int NUM_OBJ    = 32,
    parameter int IDX_W      = $clog2(NUM_OBJ),
    parameter int ID_W       = 29,
    parameter int DATA_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    found_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    remote_i,
    input  logic [7:0]              flags_i,
    input  logic [ID_W-1:0]         id_i,
    input  logic                    ide_i,
    input  logic                    rtr_i,
    input  logic [3:0]              dlc_i,
    input  logic [8*DATA_BYTES-1:0] data_i,
    input  logic [ID_W-1:0]         rx_id_i,
    input  logic                    rx_ide_i,
    input  logic                    rx_rtr_i,
    input  logic [3:0]              rx_dlc_i,
    input  logic [8*DATA_BYTES-1:0] rx_data_i,
    input  logic                    clr_i,
    input  logic [IDX_W-1:0]        clr_idx_i,
    input  logic                    clr_newdat_i,
    input  logic                    clr_lost_i,
    output logic                    busy_o,
    output logic                    wr_o,
    output logic [IDX_W-1:0]        wr_idx_o,
    output logic [7:0]              flags_o,
    output logic [ID_W-1:0]         id_o,
    output logic                    ide_o,
    output logic                    rtr_o,
    output logic [3:0]              dlc_o,
    output logic [8*DATA_BYTES-1:0] data_o,
    output logic [NUM_OBJ-1:0]      irq_o
);
    localparam int DW = 8 * DATA_BYTES;

    typedef struct packed {
        logic              busy;
        logic              act;
        logic              irq;
        logic [IDX_W-1:0]  idx;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] set;
        logic [ID_W-1:0]   id;
        logic              ide;
        logic              rtr;
        logic [3:0]        dlc;
        logic [DW-1:0]     data;
    } upd_st_t;

    upd_st_t st_d, st_q;

    logic              accept;
    logic [FLAG_W-1:0] clr_acc, clr_wr, flags_eff, rule_flags, rule_set;
    upd_kind_e         kind;

    // clear aimed at the object being read now
    rx_obj_clr_mask #(.IDX_W(IDX_W)) u_clr_acc (
        .clr_i(clr_i), .clr_idx_i(clr_idx_i), .idx_i(idx_i),
        .clr_newdat_i(clr_newdat_i), .clr_lost_i(clr_lost_i), .mask_o(clr_acc)
    );

    // clear aimed at the object being written now
    rx_obj_clr_mask #(.IDX_W(IDX_W)) u_clr_wr (
        .clr_i(clr_i), .clr_idx_i(clr_idx_i), .idx_i(st_q.idx),
        .clr_newdat_i(clr_newdat_i), .clr_lost_i(clr_lost_i), .mask_o(clr_wr)
    );

    assign flags_eff = flags_i & ~clr_acc;

    rx_obj_rules u_rules (
        .found_i(found_i), .remote_i(remote_i), .flags_i(flags_eff),
        .kind_o(kind), .flags_o(rule_flags), .set_o(rule_set)
    );

    always_comb begin
        accept     = start_i && !st_q.busy;
        st_d       = st_q;
        st_d.busy  = accept;
        st_d.act   = 1'b0;
        st_d.irq   = 1'b0;
        if (accept) begin
            st_d.act   = (kind != UPD_NONE);
            st_d.irq   = rule_set[F_IPND];
            st_d.idx   = idx_i;
            st_d.flags = rule_flags;
            st_d.set   = rule_set;
            st_d.id    = id_i;
            st_d.ide   = ide_i;
            st_d.rtr   = rtr_i;
            st_d.dlc   = dlc_i;
            st_d.data  = data_i;
            if (kind == UPD_DATA || kind == UPD_RMT_STORE) begin
                st_d.id  = rx_id_i;
                st_d.ide = rx_ide_i;
                st_d.rtr = rx_rtr_i;
                st_d.dlc = rx_dlc_i;
            end
            if (kind == UPD_DATA) begin
                st_d.data = rx_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rx_obj_onehot #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_irq (
        .en_i(st_q.busy && st_q.act && st_q.irq), .idx_i(st_q.idx), .vec_o(irq_o)
    );

    assign busy_o   = st_q.busy;
    assign wr_o     = st_q.busy && st_q.act;
    assign wr_idx_o = st_q.idx;
    assign flags_o  = (st_q.flags & ~clr_wr) | st_q.set;
    assign id_o     = st_q.id;
    assign ide_o    = st_q.ide;
    assign rtr_o    = st_q.rtr;
    assign dlc_o    = st_q.dlc;
    assign data_o   = st_q.data;
endmodule

// File: rtl/rx_obj_update_chk.sv
module rx_obj_update_chk
    import rx_obj_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int DW      = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               found_i,
    input logic               remote_i,
    input logic [7:0]         flags_i,
    input logic [DW-1:0]      data_i,
    input logic               busy_o,
    input logic               wr_o,
    input logic [7:0]         flags_o,
    input logic [DW-1:0]      data_o,
    input logic [NUM_OBJ-1:0] irq_o
);
    logic acc_hit;
    assign acc_hit = start_i && !busy_o && found_i;

    a_r2_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o);
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);
    a_r2_wr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> busy_o);
    a_r3_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && !found_i |=> !wr_o);
    a_r4_data_flags: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && !remote_i |=> wr_o && flags_o[F_NEWD] && !flags_o[F_TXRQ]);
    a_r6_irq_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    a_r6_irq_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> wr_o);
    a_r7_remote_tx: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && remote_i && flags_i[F_DIR] && flags_i[F_RMTEN]
        |=> wr_o && flags_o[F_TXRQ] && data_o == $past(data_i));
    a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && remote_i && !(flags_i[F_DIR] && (flags_i[F_RMTEN] || flags_i[F_UMASK]))
        |=> !wr_o);
    a_r9_remote_store: assert property (@(posedge clk) disable iff (!rst_n)
        acc_hit && remote_i && flags_i[F_DIR] && !flags_i[F_RMTEN] && flags_i[F_UMASK]
        |=> wr_o && !flags_o[F_TXRQ] && flags_o[F_NEWD] && data_o == $past(data_i));
endmodule

bind rx_obj_update rx_obj_update_chk #(.NUM_OBJ(NUM_OBJ), .DW(8*DATA_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .found_i(found_i),
    .remote_i(remote_i), .flags_i(flags_i), .data_i(data_i),
    .busy_o(busy_o), .wr_o(wr_o), .flags_o(flags_o), .data_o(data_o), .irq_o(irq_o)
);

// File: tb/test_rx_obj_update.sv
module test_rx_obj_update;
    localparam int NUM_OBJ = 32;
    localparam int IDX_W   = 5;
    localparam int ID_W    = 29;
    localparam int DW      = 64;

    localparam logic [ID_W-1:0] OBJ_ID  = 29'h00ABC123;
    localparam logic [ID_W-1:0] RX_ID   = 29'h12345678;
    localparam logic [DW-1:0]   OBJ_DAT = 64'h1111_2222_3333_4444;
    localparam logic [DW-1:0]   RX_DAT  = 64'hDEAD_BEEF_CAFE_F00D;

    typedef struct packed {
        logic       remote;
        logic [7:0] fin;
        logic       wr;
        logic [7:0] fout;
        logic       arb_rx;
        logic       dat_rx;
        logic       irq;
    } vec_t;

    // flags: 7 Dir, 6 UMask, 5 RmtEn, 4 RxIE, 3 IntPnd, 2 MsgLst, 1 NewDat, 0 TxRqst
    localparam vec_t VECS [9] = '{
        '{1'b0, 8'h01, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0},  // R4 data clears TxRqst
        '{1'b0, 8'h12, 1'b1, 8'h1E, 1'b1, 1'b1, 1'b1},  // R5 R6 overwrite, RxIE
        '{1'b0, 8'h10, 1'b1, 8'h1A, 1'b1, 1'b1, 1'b1},  // R6 RxIE, no loss
        '{1'b0, 8'h06, 1'b1, 8'h06, 1'b1, 1'b1, 1'b0},  // R5 MsgLst held
        '{1'b1, 8'hA0, 1'b1, 8'hA1, 1'b0, 1'b0, 1'b0},  // R7 UMask 0
        '{1'b1, 8'hE2, 1'b1, 8'hE3, 1'b0, 1'b0, 1'b0},  // R7 UMask 1
        '{1'b1, 8'h81, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},  // R8 ignored
        '{1'b1, 8'hC1, 1'b1, 8'hC2, 1'b1, 1'b0, 1'b0},  // R9 stored as data
        '{1'b1, 8'h41, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}   // R8 Dir 0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, found_i = 1'b0, remote_i = 1'b0;
    logic [IDX_W-1:0] idx_i = '0, clr_idx_i = '0;
    logic [7:0] flags_i = '0;
    logic clr_i = 1'b0, clr_newdat_i = 1'b0, clr_lost_i = 1'b0;
    logic busy_o, wr_o, ide_o, rtr_o;
    logic [IDX_W-1:0] wr_idx_o;
    logic [7:0] flags_o;
    logic [ID_W-1:0] id_o;
    logic [3:0] dlc_o;
    logic [DW-1:0] data_o;
    logic [NUM_OBJ-1:0] irq_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_obj_update #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .ID_W(ID_W), .DATA_BYTES(8)) i_rx_obj_update (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .found_i(found_i), .idx_i(idx_i),
        .remote_i(remote_i), .flags_i(flags_i), .id_i(OBJ_ID), .ide_i(1'b0), .rtr_i(1'b0),
        .dlc_i(4'd3), .data_i(OBJ_DAT), .rx_id_i(RX_ID), .rx_ide_i(1'b1), .rx_rtr_i(remote_i),
        .rx_dlc_i(4'd8), .rx_data_i(RX_DAT), .clr_i(clr_i), .clr_idx_i(clr_idx_i),
        .clr_newdat_i(clr_newdat_i), .clr_lost_i(clr_lost_i), .busy_o(busy_o), .wr_o(wr_o),
        .wr_idx_o(wr_idx_o), .flags_o(flags_o), .id_o(id_o), .ide_o(ide_o), .rtr_o(rtr_o),
        .dlc_o(dlc_o), .data_o(data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic launch(input logic rem, input logic [7:0] f, input logic [IDX_W-1:0] ix);
        start_i = 1'b1; found_i = 1'b1; remote_i = rem; flags_i = f; idx_i = ix;
        step();
        start_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", 64'(busy_o), 64'd0);
        check("R1", "irq in reset", 64'(irq_o), 64'd0);
        rst_n = 1'b1;
        step();
        check("R1", "wr after reset", 64'(wr_o), 64'd0);

        for (int k = 0; k < 9; k++) begin
            launch(VECS[k].remote, VECS[k].fin, 5'd5);
            check("R2", "busy", 64'(busy_o), 64'd1);
            check("R4-R9 vec", "wr", 64'(wr_o), 64'(VECS[k].wr));
            if (VECS[k].wr) begin
                check("R2", "wr_idx", 64'(wr_idx_o), 64'd5);
                check("R4-R9 vec", "flags", 64'(flags_o), 64'(VECS[k].fout));
                check("R4 R9 vec", "id", 64'(id_o), VECS[k].arb_rx ? 64'(RX_ID) : 64'(OBJ_ID));
                check("R4 R9 vec", "dlc", 64'(dlc_o), VECS[k].arb_rx ? 64'd8 : 64'd3);
                check("R4 R9 vec", "ide", 64'(ide_o), 64'(VECS[k].arb_rx));
                check("R4 R9 vec", "rtr", 64'(rtr_o), VECS[k].arb_rx ? 64'(VECS[k].remote) : 64'd0);
                check("R4 R7 R9 vec", "data", data_o, VECS[k].dat_rx ? RX_DAT : OBJ_DAT);
            end
            check("R6 vec", "irq", 64'(irq_o), VECS[k].irq ? 64'(32'h20) : 64'd0);
            step();
            check("R2", "busy drops", 64'(busy_o), 64'd0);
        end

        // R3 no match
        start_i = 1'b1; found_i = 1'b0; remote_i = 1'b0; flags_i = 8'h10;
        step();
        start_i = 1'b0;
        check("R3", "wr on miss", 64'(wr_o), 64'd0);
        check("R3", "irq on miss", 64'(irq_o), 64'd0);
        step();

        // R2 start held during busy is ignored
        start_i = 1'b1; found_i = 1'b1; remote_i = 1'b0; flags_i = 8'h00; idx_i = 5'd7;
        step();
        check("R2", "first write", 64'(wr_o), 64'd1);
        idx_i = 5'd9;
        step();
        start_i = 1'b0;
        check("R2", "second start ignored busy", 64'(busy_o), 64'd0);
        check("R2", "second start ignored wr", 64'(wr_o), 64'd0);
        step();

        // R10 clear in write cycle: set wins for NewDat, clear of MsgLst applies
        launch(1'b1, 8'hA6, 5'd3);
        clr_i = 1'b1; clr_idx_i = 5'd3; clr_newdat_i = 1'b1; clr_lost_i = 1'b1;
        #0.5;
        check("R10", "remote tx with clear", 64'(flags_o), 64'hA1);
        clr_i = 1'b0;
        step();

        launch(1'b0, 8'h04, 5'd3);
        clr_i = 1'b1;
        #0.5;
        check("R10", "data with clear", 64'(flags_o), 64'h02);
        clr_i = 1'b0;
        step();

        // R10 clear in accept cycle decides MsgLst
        clr_i = 1'b1; clr_idx_i = 5'd4; clr_newdat_i = 1'b1; clr_lost_i = 1'b0;
        launch(1'b0, 8'h02, 5'd4);
        clr_i = 1'b0;
        check("R10", "accept-cycle clear", 64'(flags_o), 64'h02);
        step();

        // R10 clear on another object has no effect
        launch(1'b0, 8'h02, 5'd4);
        clr_i = 1'b1; clr_idx_i = 5'd6; clr_newdat_i = 1'b1; clr_lost_i = 1'b1;
        #0.5;
        check("R10", "other index clear", 64'(flags_o), 64'h06);
        clr_i = 1'b0;
        step();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule